// File: doc/BRIEF.md
# Serial Leading-One Log2 Converter

This block turns a 20-bit pulse total into an 8-bit base-2 logarithm. The result has a 5-bit exponent (the characteristic) and a 3-bit fractional code (the mantissa). A timing controller supplies the count and a starting exponent, then pulses `start`. The block copies the count into a 21-bit normalization register and shifts it left by one place per clock. Each shift takes one off the exponent. Shifting stops when the leading one reaches the top bit. The four bits just below the leading one then pass through a fixed, nonuniform table to give the mantissa, and both fields are captured in an output register.

While shifting, the block feeds ones into the vacated low bits, so a zero count still terminates. A run of ones directly after the leading one rounds up to the next power of two. In that case shifting stops one place early and the mantissa is zero. The captured word stays unchanged until the next conversion finishes, so a converter further down the chain always sees a stable value.

Top module: `lognorm_conv`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `log_char` and `log_mant` are all 0.
- R2: When `start` is high at a rising edge while `busy` is low, the block samples `count_in` and `preset_in` and raises `busy` from the next cycle.
- R3: For a nonzero count whose highest set bit is at index p (0..19), and with no round-up, the characteristic is `preset_in` minus (20 - p).
- R4: The mantissa comes from the four bits after the leading one, written f3..f0 with f3 nearest the leading one. The codes are: 0000 gives 000, 0001 gives 001, 001x gives 010, 010x gives 011, 011x gives 100, 100x gives 101, 101x gives 110, and 1100, 1101 and 1110 give 111.
- R5: When those four bits are 1111, the mantissa is 000 and the characteristic is `preset_in` minus (19 - p), one decrement fewer than R3 would give.
- R6: Bits below bit 0 of the count are read as ones. A count of 0 therefore finishes after 20 shifts with mantissa 000 and characteristic `preset_in` - 20, and a count of 1 rounds up per R5.
- R7: With S shifts, `done` is high for exactly one cycle, S+1 clock edges after the edge that accepted `start`. `busy` falls on that same edge.
- R8: A `start` that arrives while `busy` is high is ignored; the result in progress is not disturbed.
- R9: `log_char` and `log_mant` change only on the edge that raises `done`, and hold their value at all other times.
- R10: The characteristic subtraction wraps modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| count_in | input | 20 | Accumulated pulse count |
| preset_in | input | 5 | Starting characteristic from the timing controller |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is captured |
| log_char | output | 5 | Held characteristic |
| log_mant | output | 3 | Held mantissa |

## Verification
The bench checks the three worked counts 467, 4670 and 46700 with a starting exponent of 30. It also walks every 4-bit fraction code, so a table that is off by one row would report a wrong mantissa at a known count. It drives the round-up pattern in three places: at the top bit, at a small count and at count 1. It also drives a zero count. A design that feeds in zeros instead of ones would never stop on a zero count, and a design that rounds a step late would report an exponent one too low. A `start` pulse sent in the middle of a run, and a small exponent that must wrap, catch a design that restarts while busy or saturates instead of wrapping.

// File: rtl/lognorm_pkg.sv
package lognorm_pkg;
    localparam int CNT_W  = 20;
    localparam int NORM_W = CNT_W + 1;
    localparam int CHAR_W = 5;
    localparam int MANT_W = 3;
    localparam int FRAC_W = 4;

    typedef enum logic {ST_IDLE, ST_RUN} conv_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] chr;
        logic [MANT_W-1:0] mant;
    } log_word_t;

    // Nonuniform 4-to-3 fraction table; 1111 is handled as round-up upstream
    function automatic logic [MANT_W-1:0] frac_to_mant(input logic [FRAC_W-1:0] f);
        logic [MANT_W-1:0] m;
        case (f)
            4'b0000:                   m = 3'd0;
            4'b0001:                   m = 3'd1;
            4'b0010, 4'b0011:          m = 3'd2;
            4'b0100, 4'b0101:          m = 3'd3;
            4'b0110, 4'b0111:          m = 3'd4;
            4'b1000, 4'b1001:          m = 3'd5;
            4'b1010, 4'b1011:          m = 3'd6;
            4'b1100, 4'b1101, 4'b1110: m = 3'd7;
            default:                   m = 3'd0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/norm_shifter.sv
module norm_shifter #(
    parameter int NORM_W = lognorm_pkg::NORM_W,
    parameter int FRAC_W = lognorm_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [NORM_W-2:0] load_val,
    output logic              lead_top,
    output logic              round_hit,
    output logic [FRAC_W-1:0] frac
);
    localparam int TOP = NORM_W - 1;

    logic [NORM_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (load)  sr_q <= {1'b0, load_val};
        else if (shift) sr_q <= {sr_q[NORM_W-2:0], 1'b1};
    end

    assign lead_top  = sr_q[TOP];
    assign round_hit = !sr_q[TOP] && (&sr_q[TOP-1 -: FRAC_W+1]);
    assign frac      = round_hit ? '0 : sr_q[TOP-1 -: FRAC_W];

    // R6
    shift_fill_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> sr_q[0]);
endmodule

// File: rtl/exp_counter.sv
module exp_counter #(
    parameter int CHAR_W = lognorm_pkg::CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              dec,
    input  logic [CHAR_W-1:0] preset,
    output logic [CHAR_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= preset;
        else if (dec)  value <= value - 1'b1;
    end

    // R8
    exp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(value));
endmodule

// File: rtl/mant_map.sv
module mant_map #(
    parameter int FRAC_W = lognorm_pkg::FRAC_W,
    parameter int MANT_W = lognorm_pkg::MANT_W
) (
    input  logic [FRAC_W-1:0] frac,
    output logic [MANT_W-1:0] mant
);
    always_comb mant = lognorm_pkg::frac_to_mant(frac);
endmodule

// File: rtl/lognorm_conv.sv
module lognorm_conv
    import lognorm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [CHAR_W-1:0] preset_in,
    output logic              busy,
    output logic              done,
    output logic [CHAR_W-1:0] log_char,
    output logic [MANT_W-1:0] log_mant
);
    localparam int RUN_W = $clog2(NORM_W + 2) + 1;

    conv_state_e       state_q;
    logic              lead_top, round_hit, term;
    logic              load, shift, finish;
    logic [FRAC_W-1:0] frac;
    logic [MANT_W-1:0] mant_c;
    logic [CHAR_W-1:0] exp_v;
    log_word_t         word_q;

    assign term   = lead_top || round_hit;
    assign load   = (state_q == ST_IDLE) && start;
    assign shift  = (state_q == ST_RUN) && !term;
    assign finish = (state_q == ST_RUN) && term;

    norm_shifter #(.NORM_W(NORM_W), .FRAC_W(FRAC_W)) shf_i (
        .clk(clk), .rst(rst), .load(load), .shift(shift), .load_val(count_in),
        .lead_top(lead_top), .round_hit(round_hit), .frac(frac)
    );

    exp_counter #(.CHAR_W(CHAR_W)) exp_i (
        .clk(clk), .rst(rst), .load(load), .dec(shift),
        .preset(preset_in), .value(exp_v)
    );

    mant_map #(.FRAC_W(FRAC_W), .MANT_W(MANT_W)) map_i (
        .frac(frac), .mant(mant_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load)   state_q <= ST_RUN;
            if (finish) begin
                state_q     <= ST_IDLE;
                word_q.chr  <= exp_v;
                word_q.mant <= mant_c;
            end
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign log_char = word_q.chr;
    assign log_mant = word_q.mant;

    // Run-length counter used only by the bound check below
    logic [RUN_W-1:0] run_len_q;
    always_ff @(posedge clk) begin
        if (rst || load) run_len_q <= '0;
        else if (busy)   run_len_q <= run_len_q + 1'b1;
    end

    // R6
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len_q <= RUN_W'(NORM_W)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(log_char) && $stable(log_mant)));
    // R5
    round_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && round_hit) |=> (log_mant == '0));
endmodule

// File: tb/lognorm_conv_tb.sv
`timescale 1ns/1ps
module lognorm_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] count_in = '0;
    logic [4:0]  preset_in = '0;
    logic        busy, done;
    logic [4:0]  log_char;
    logic [2:0]  log_mant;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lognorm_conv dut_i (
        .clk(clk), .rst(rst), .start(start), .count_in(count_in),
        .preset_in(preset_in), .busy(busy), .done(done),
        .log_char(log_char), .log_mant(log_mant)
    );

    // Expected result from the requirements (R3..R6, R10)
    function automatic void ref_conv(input logic [19:0] cnt, input logic [4:0] pre,
                                     output logic [4:0] c, output logic [2:0] m,
                                     output int sh);
        int p;
        logic [23:0] ext;
        logic [3:0] f;
        if (cnt == 0) begin
            sh = 20;
            m  = 3'd0;
        end else begin
            p = 0;
            for (int i = 0; i < 20; i++) if (cnt[i]) p = i;
            ext = {cnt, 4'b1111};
            f = 4'(ext >> p);
            if (f == 4'hF) begin
                m  = 3'd0;
                sh = 19 - p;
            end else begin
                if (f == 0)      m = 3'd0;
                else if (f == 1) m = 3'd1;
                else if (f >= 12) m = 3'd7;
                else             m = 3'(int'(f) / 2 + 1);
                sh = 20 - p;
            end
        end
        c = pre - 5'(sh);
    endfunction

    // Cycle-accurate behavioural model
    int         m_busy = 0, m_left = 0, m_done = 0;
    logic [4:0] m_char = '0, r_char = '0;
    logic [2:0] m_mant = '0, r_mant = '0;

    always @(posedge clk) begin
        logic [4:0] c;
        logic [2:0] m;
        int s;
        if (rst) begin
            m_busy <= 0; m_left <= 0; m_done <= 0; m_char <= '0; m_mant <= '0;
        end else begin
            m_done <= 0;
            if (m_busy == 0 && start) begin
                ref_conv(count_in, preset_in, c, m, s);
                r_char <= c; r_mant <= m;
                m_busy <= 1; m_left <= s;
            end else if (m_busy != 0) begin
                if (m_left == 0) begin
                    m_busy <= 0; m_done <= 1;
                    m_char <= r_char; m_mant <= r_mant;
                end else m_left <= m_left - 1;
            end
        end
    end

    // Compare every cycle away from the active edge (R2, R7, R9)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (busy !== (m_busy != 0) || done !== (m_done != 0) ||
                log_char !== m_char || log_mant !== m_mant) begin
                errors++;
                $display("FAIL R2/R7/R9 cycle %0d: busy=%b done=%b char=%b mant=%b exp busy=%0d done=%0d char=%b mant=%b",
                         cycles, busy, done, log_char, log_mant, m_busy, m_done, m_char, m_mant);
            end
        end
    end

    task automatic check(input string tag, input logic [4:0] ec, input logic [2:0] em);
        checks++;
        if (log_char !== ec || log_mant !== em) begin
            errors++;
            $display("FAIL %s: char=%b mant=%b expected char=%b mant=%b", tag, log_char, log_mant, ec, em);
        end
    endtask

    task automatic convert(input logic [19:0] cnt, input logic [4:0] pre);
        @(negedge clk);
        start = 1'b1; count_in = cnt; preset_in = pre;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    endtask

    task automatic conv_ref(input string tag, input logic [19:0] cnt, input logic [4:0] pre);
        logic [4:0] c;
        logic [2:0] m;
        int s;
        ref_conv(cnt, pre, c, m, s);
        convert(cnt, pre);
        check(tag, c, m);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || log_char !== 5'd0 || log_mant !== 3'd0) begin
            errors++;
            $display("FAIL R1: busy=%b done=%b char=%b mant=%b expected all 0", busy, done, log_char, log_mant);
        end
        // R3 R4 worked examples
        convert(20'd467, 5'd30);   check("R3 467", 5'b10010, 3'b111);
        convert(20'd4670, 5'd30);  check("R3 4670", 5'b10110, 3'b010);
        convert(20'd46700, 5'd30); check("R4 46700", 5'b11001, 3'b100);
        // R4 every fraction code, R5 at 31
        for (int v = 16; v < 32; v++) conv_ref("R4 sweep", 20'(v), 5'd31);
        convert(20'd31, 5'd31);       check("R5 31", 5'd16, 3'd0);
        convert(20'hFFFFF, 5'd31);    check("R5 top", 5'd31, 3'd0);
        convert(20'h80000, 5'd31);    check("R3 msb", 5'd30, 3'd0);
        // R6 zero and one
        convert(20'd0, 5'd31);        check("R6 zero", 5'd11, 3'd0);
        convert(20'd1, 5'd31);        check("R6 one", 5'd12, 3'd0);
        // R10 wrap
        convert(20'd1, 5'd3);         check("R10 wrap", 5'd16, 3'd0);
        // R8 start while busy
        @(negedge clk);
        start = 1'b1; count_in = 20'd1; preset_in = 5'd31;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; count_in = 20'h80000; preset_in = 5'd7;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
        check("R8 ignored", 5'd12, 3'd0);
        // R9 hold across idle cycles
        repeat (10) @(negedge clk);
        check("R9 hold", 5'd12, 3'd0);
        // Pseudo-random counts
        begin
            logic [19:0] lf = 20'h5A3C1;
            for (int n = 0; n < 40; n++) begin
                lf = {lf[18:0], lf[19] ^ lf[16]};
                conv_ref("R3 random", lf >> (n % 18), 5'(25 + n % 7));
            end
        end
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule